// File: doc/BRIEF.md
# Requester ID Remapping Unit

This unit sits between a PCIe root complex and a set of IOMMUs. Each 16-bit requester ID it receives names a bus (bits 15:8), a device (bits 7:3) and a function (bits 2:0). The unit returns two things: the index of the IOMMU that must handle the transaction, and the sideband stream identifier to send to that IOMMU. Software sets up the mapping by writing a global ID mask and a small table of range entries through a single-cycle write port.

The incoming ID is first ANDed with the mask. The masked value is then compared against every valid entry. Each entry matches a half-open interval, from its base up to but not including base plus length. The lowest-numbered matching entry wins. On a hit, the stream identifier is the masked ID minus the entry base plus the entry's output base. If no entry matches, a miss is reported.

Lookups use a valid/ready handshake. One request is accepted per cycle, and the result is registered and appears one cycle after acceptance. The response is held steady while it is not taken.

Top module: `rid_remap`

## Requirements
- R1: After reset every entry is invalid and the mask is 0xFFFF, so every lookup reports a miss.
- R2: The mask is ANDed with the requester ID before any matching. With a mask of 0xFFF8, every function of a device maps to the same result.
- R3: An entry matches a masked ID r only when base <= r < base + length. The ID equal to base + length does not match.
- R4: On a hit, rsp_iommu is the entry's IOMMU index and rsp_sid is (r - base + output base) truncated to 16 bits.
- R5: When several valid entries match, the entry with the lowest index supplies the result.
- R6: On a miss, rsp_miss is 1 and both rsp_sid and rsp_iommu are 0.
- R7: Range bounds are computed without overflow. A 17-bit length of 0x10000 with base 0 covers every ID, and an entry whose base + length exceeds 0xFFFF still matches up to 0xFFFF.
- R8: Two entries that exchange the lower and upper halves of the ID space, in effect flipping bit 15, give the expected IDs, each on its own IOMMU index.
- R9: A request accepted at a clock edge (req_valid and req_ready high) produces rsp_valid high after that edge, holding the result of that request.
- R10: While rsp_valid is high and rsp_ready is low, req_ready is low and the response fields stay unchanged.
- R11: A table write in the same cycle as an accepted lookup does not affect that lookup. It applies from the next lookup onward.
- R12: Writing an entry with the valid bit at 0 removes it from matching, so lookups fall through to higher-indexed entries or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mask_we | input | 1 | Write strobe for the ID mask |
| cfg_mask | input | 16 | New mask value |
| cfg_ent_we | input | 1 | Write strobe for one table entry |
| cfg_ent_idx | input | 3 | Entry number being written |
| cfg_ent_vld | input | 1 | Valid bit for the written entry |
| cfg_ent_base | input | 16 | First ID of the range |
| cfg_ent_len | input | 17 | Number of IDs in the range |
| cfg_ent_obase | input | 16 | Stream ID produced for the first ID |
| cfg_ent_iommu | input | 2 | Target IOMMU index |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request |
| req_rid | input | 16 | Requester ID to look up |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_miss | output | 1 | No entry matched |
| rsp_iommu | output | 2 | Selected IOMMU index |
| rsp_sid | output | 16 | Sideband stream identifier |

## Verification
The hardest case to reach from the ports is a table write landing in the same cycle as an accepted lookup. The bench drives both in one cycle and checks that the response still reflects the old table, then looks up the same ID again to confirm the new entry applies. Another case needing care is overlapping ranges combined with a sum that goes past 16 bits. The bench programs overlapping entries, an entry whose output base wraps, and an entry whose range runs past 0xFFFF, then probes each of them at its first, last and first-excluded ID.

// File: rtl/rid_remap.sv
module rid_remap #(
  parameter int ID_W    = 16,
  parameter int ENTRIES = 8,
  parameter int IOMMU_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_mask_we,
  input  logic [ID_W-1:0]            cfg_mask,
  input  logic                       cfg_ent_we,
  input  logic [$clog2(ENTRIES)-1:0] cfg_ent_idx,
  input  logic                       cfg_ent_vld,
  input  logic [ID_W-1:0]            cfg_ent_base,
  input  logic [ID_W:0]              cfg_ent_len,
  input  logic [ID_W-1:0]            cfg_ent_obase,
  input  logic [IOMMU_W-1:0]         cfg_ent_iommu,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ID_W-1:0]            req_rid,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       rsp_miss,
  output logic [IOMMU_W-1:0]         rsp_iommu,
  output logic [ID_W-1:0]            rsp_sid
);
  localparam int ENT_W = $clog2(ENTRIES);
  localparam int LEN_W = ID_W + 1;
  localparam int SUM_W = ID_W + 2;

  logic [ID_W-1:0]    mask_q;
  logic [ENTRIES-1:0] vld_q;
  logic [ID_W-1:0]    base_q  [ENTRIES];
  logic [LEN_W-1:0]   len_q   [ENTRIES];
  logic [ID_W-1:0]    obase_q [ENTRIES];
  logic [IOMMU_W-1:0] iommu_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      vld_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i]  <= '0;
        len_q[i]   <= '0;
        obase_q[i] <= '0;
        iommu_q[i] <= '0;
      end
    end else begin
      if (cfg_mask_we) mask_q <= cfg_mask;
      if (cfg_ent_we) begin
        vld_q[cfg_ent_idx]   <= cfg_ent_vld;
        base_q[cfg_ent_idx]  <= cfg_ent_base;
        len_q[cfg_ent_idx]   <= cfg_ent_len;
        obase_q[cfg_ent_idx] <= cfg_ent_obase;
        iommu_q[cfg_ent_idx] <= cfg_ent_iommu;
      end
    end
  end

  wire [ID_W-1:0] masked = req_rid & mask_q;

  logic [ENTRIES-1:0] hit;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = vld_q[g] && (masked >= base_q[g]) &&
                    (SUM_W'(masked) < SUM_W'(base_q[g]) + SUM_W'(len_q[g]));
  end

  logic [ENT_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit[i]) sel = ENT_W'(i);
  end

  wire            found   = |hit;
  wire [ID_W-1:0] sid_hit = masked - base_q[sel] + obase_q[sel];
  wire            accept  = req_valid && req_ready;

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_iommu <= '0;
      rsp_sid   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_miss  <= !found;
      rsp_iommu <= found ? iommu_q[sel] : '0;
      rsp_sid   <= found ? sid_hit : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R9
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_sid) && $stable(rsp_iommu) && $stable(rsp_miss)); // R10
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_miss |-> rsp_sid == '0 && rsp_iommu == '0); // R6
  AST_RESET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) ##1 (req_valid && req_ready) |=> rsp_miss); // R1
endmodule

// File: tb/tb_rid_remap.sv
module tb_rid_remap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  localparam logic [15:0] VR [NV] = '{16'h0100, 16'h010F, 16'h0110, 16'h01FF, 16'h0200,
                                      16'h00FF, 16'hFFF0, 16'hFFFF, 16'h8000, 16'h800F, 16'h8010};
  localparam logic [18:0] VX [NV] = '{{1'b0,2'd1,16'h5000}, {1'b0,2'd1,16'h500F},
                                      {1'b0,2'd2,16'h0010}, {1'b0,2'd2,16'h00FF},
                                      {1'b1,2'd0,16'h0000}, {1'b1,2'd0,16'h0000},
                                      {1'b0,2'd3,16'h1234}, {1'b0,2'd3,16'h1243},
                                      {1'b0,2'd1,16'hFFF8}, {1'b0,2'd1,16'h0007},
                                      {1'b1,2'd0,16'h0000}};

  logic clk = 0, rst_n = 0;
  logic cfg_mask_we = 0, cfg_ent_we = 0, cfg_ent_vld = 0;
  logic [15:0] cfg_mask = 0, cfg_ent_base = 0, cfg_ent_obase = 0, req_rid = 0;
  logic [2:0]  cfg_ent_idx = 0;
  logic [16:0] cfg_ent_len = 0;
  logic [1:0]  cfg_ent_iommu = 0;
  logic req_valid = 0, rsp_ready = 1;
  logic req_ready, rsp_valid, rsp_miss;
  logic [1:0] rsp_iommu;
  logic [15:0] rsp_sid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rid_remap dut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_ent(input logic [2:0] idx, input logic v, input logic [15:0] b,
                        input logic [16:0] l, input logic [15:0] ob, input logic [1:0] io);
    @(negedge clk);
    cfg_ent_we = 1; cfg_ent_idx = idx; cfg_ent_vld = v; cfg_ent_base = b;
    cfg_ent_len = l; cfg_ent_obase = ob; cfg_ent_iommu = io;
    @(negedge clk);
    cfg_ent_we = 0;
  endtask

  task automatic wr_mask(input logic [15:0] m);
    @(negedge clk);
    cfg_mask_we = 1; cfg_mask = m;
    @(negedge clk);
    cfg_mask_we = 0;
  endtask

  task automatic look(input logic [15:0] rid, input string tag, input logic [18:0] exp);
    @(negedge clk);
    req_valid = 1; req_rid = rid;
    @(negedge clk);
    req_valid = 0;
    check({tag, " valid"}, 32'(rsp_valid), 32'd1);
    check(tag, {13'd0, rsp_miss, rsp_iommu, rsp_sid}, {13'd0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R1 reset req_ready", 32'(req_ready), 1);
    look(16'h0100, "R1 reset miss", {1'b1, 2'd0, 16'h0});
    look(16'hFFFF, "R1 R6 reset miss high", {1'b1, 2'd0, 16'h0});

    wr_ent(0, 1, 16'h0100, 17'h00010, 16'h5000, 1);
    wr_ent(1, 1, 16'h0100, 17'h00100, 16'h0000, 2);
    wr_ent(2, 1, 16'hFFF0, 17'h00020, 16'h1234, 3);
    wr_ent(3, 1, 16'h8000, 17'h00010, 16'hFFF8, 1);
    // R3 R4 R5 R6 R7 vectors
    for (int i = 0; i < NV; i++)
      look(VR[i], $sformatf("R3/R4/R5/R6/R7 vector %0d", i), VX[i]);

    // R2 mask
    wr_ent(4, 1, 16'h0300, 17'h00001, 16'h0AAA, 2);
    look(16'h0305, "R2 unmasked miss", {1'b1, 2'd0, 16'h0});
    wr_mask(16'hFFF8);
    look(16'h0305, "R2 masked fn5", {1'b0, 2'd2, 16'h0AAA});
    look(16'h0307, "R2 masked fn7", {1'b0, 2'd2, 16'h0AAA});
    wr_mask(16'hFFFF);

    // R12 disable entry 0
    wr_ent(0, 0, 16'h0100, 17'h00010, 16'h5000, 1);
    look(16'h0105, "R12 falls to entry1", {1'b0, 2'd2, 16'h0005});
    wr_ent(1, 0, 16'h0100, 17'h00100, 16'h0000, 2);
    look(16'h0105, "R12 all disabled miss", {1'b1, 2'd0, 16'h0});

    // R8 half swap
    wr_ent(2, 0, 0, 0, 0, 0);
    wr_ent(3, 0, 0, 0, 0, 0);
    wr_ent(4, 0, 0, 0, 0, 0);
    wr_ent(0, 1, 16'h0000, 17'h08000, 16'h8000, 0);
    wr_ent(1, 1, 16'h8000, 17'h08000, 16'h0000, 1);
    look(16'h1234, "R8 low half", {1'b0, 2'd0, 16'h9234});
    look(16'h7FFF, "R8 low top", {1'b0, 2'd0, 16'hFFFF});
    look(16'h8001, "R8 high half", {1'b0, 2'd1, 16'h0001});
    look(16'hFFFF, "R8 high top", {1'b0, 2'd1, 16'h7FFF});

    // R7 full-space entry
    wr_ent(0, 0, 0, 0, 0, 0);
    wr_ent(1, 0, 0, 0, 0, 0);
    wr_ent(5, 1, 16'h0000, 17'h10000, 16'h0000, 3);
    look(16'hABCD, "R7 full space", {1'b0, 2'd3, 16'hABCD});
    look(16'hFFFF, "R7 full space top", {1'b0, 2'd3, 16'hFFFF});

    // R11 write coincident with lookup
    @(negedge clk);
    req_valid = 1; req_rid = 16'hABCD;
    cfg_ent_we = 1; cfg_ent_idx = 0; cfg_ent_vld = 1; cfg_ent_base = 16'hAB00;
    cfg_ent_len = 17'h100; cfg_ent_obase = 16'h0000; cfg_ent_iommu = 1;
    @(negedge clk);
    req_valid = 0; cfg_ent_we = 0;
    check("R11 same-cycle old table", {13'd0, rsp_miss, rsp_iommu, rsp_sid}, {13'd0, 1'b0, 2'd3, 16'hABCD});
    look(16'hABCD, "R11 next lookup new table", {1'b0, 2'd1, 16'h00CD});

    // R9 R10 backpressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_rid = 16'hAB10;
    @(negedge clk);
    check("R9 valid after accept", 32'(rsp_valid), 1);
    check("R10 ready low in stall", 32'(req_ready), 0);
    req_rid = 16'h0001;
    @(negedge clk);
    check("R10 held sid", 32'(rsp_sid), 32'h0010);
    check("R10 held iommu", 32'(rsp_iommu), 1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R10 second req after release", {13'd0, rsp_miss, rsp_iommu, rsp_sid}, {13'd0, 1'b0, 2'd3, 16'h0001});
    @(negedge clk);
    check("R9 valid drops when idle", 32'(rsp_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule